// File: doc/BRIEF.md
# Crypto Channel Soft-Reset Sequencer

This block orders the reset work for a single descriptor-processing channel of a crypto accelerator. Software triggers it through a 64-bit control word. Bit 32 asks for a full soft reset. Bit 33 asks for a partial "continue" reset. When a trigger is accepted, the sequencer looks at the channel's phase and chooses a path. If an execution unit is assigned, it asks the controller to write the soft-reset bit of the primary unit and then of the secondary unit, when one is reserved, waiting for an acknowledge each time. If the channel is only waiting for a grant, it withdraws that request. In either case it then pulses a release strobe to the arbiter.

The last step clears the channel's registers. After a full reset it also empties the fetch FIFO and clears the low half of the control word. After a continue reset both of these are kept, and a resume pulse tells the fetch logic to pick up the next queued descriptor pointer if there is one. While a sequence is running, software writes are dropped. Reads always show the live trigger bits.

The states are IDLE, DECIDE, RST_PRI, RST_SEC, RELEASE and CLEAR. The transitions are:
- IDLE→DECIDE on an accepted trigger write.
- DECIDE→RST_PRI when a primary unit is assigned.
- DECIDE→RELEASE when only a request is pending.
- DECIDE→CLEAR otherwise.
- RST_PRI→RST_SEC on acknowledge when a secondary unit is reserved.
- RST_PRI→RELEASE on acknowledge otherwise.
- RST_SEC→RELEASE on acknowledge.
- RELEASE→CLEAR always.
- CLEAR→IDLE always.

Top module: `chan_rst_seq`

## Requirements
- R1: After reset, `rd_data` is zero, `busy` is low and every strobe output is low.
- R2: A write accepted in IDLE without bit 32 or 33 stores `wr_data[31:0]`, starts nothing, and bits 63:34 of `rd_data` always read zero.
- R3: A full reset (bit 32) with no unit assigned and no request pending goes DECIDE→CLEAR. In CLEAR, `clr_regs` and `clr_fifo` are high for exactly one cycle. Afterwards `rd_data` is all zero, including bit 32 and the low 32 bits.
- R4: With a request pending and no unit assigned, `rel_pulse` is high for one cycle with no unit-reset write. CLEAR follows in the next cycle.
- R5: With a primary unit assigned, `eu_wr_req` is raised with `eu_wr_sel`=0 (0 selects the primary unit, 1 the secondary). It holds until `eu_wr_ack`. If a secondary unit is reserved, the same follows with `eu_wr_sel`=1. Then comes `rel_pulse`, then CLEAR.
- R6: A continue reset (bit 33) follows the same unit path. In CLEAR it pulses `clr_regs` and `resume` but not `clr_fifo`. It keeps `rd_data[31:0]`, and bit 33 reads zero once IDLE is re-entered.
- R7: A write with both bits 32 and 33 set runs a full reset, and bit 33 reads zero throughout.
- R8: Writes while `busy` is high change neither `rd_data` nor the sequence being run.
- R9: `busy` rises in the cycle after the trigger write and falls in the cycle IDLE is re-entered. That is 2 cycles for the direct path, 3 for the cancel path, and 3 plus the acknowledge wait of each unit for the unit path.
- R10: At most one of `rel_pulse`, `eu_wr_req` and `clr_regs` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 64 | Control-word write data |
| rd_data | output | 64 | Live control-word read value |
| req_pending | input | 1 | Channel is waiting for an execution-unit grant |
| prim_assigned | input | 1 | A primary execution unit is assigned |
| sec_reserved | input | 1 | A secondary execution unit is reserved |
| eu_wr_ack | input | 1 | Controller accepts the unit-reset write |
| eu_wr_req | output | 1 | Request a write of a unit's soft-reset bit |
| eu_wr_sel | output | 1 | Target unit of the write: 0 primary, 1 secondary |
| rel_pulse | output | 1 | One-cycle release strobe to the arbiter |
| clr_regs | output | 1 | One-cycle clear of the channel registers |
| clr_fifo | output | 1 | One-cycle clear of the fetch FIFO (full reset only) |
| resume | output | 1 | One-cycle resume strobe after a continue reset |
| busy | output | 1 | Sequence in progress |

## Verification
The main function is driven with four channel phases:
- Idle: this shows the direct DECIDE→CLEAR path.
- Grant request pending: this shows the cancel path.
- Primary unit only, with acknowledge tied high: this shows that RST_SEC is skipped.
- Primary and secondary units, with the acknowledge held back: this shows that each write request is held and that the select value is right.

The continue trigger and the combined trigger are compared against the full one. The difference shows up in which of `clr_fifo` and `resume` fires and in whether the low half of the control word survives. A write issued in the middle of a sequence shows whether it is dropped.

// File: rtl/chan_rst_pkg.sv
package chan_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_RST_PRI,
        ST_RST_SEC,
        ST_RELEASE,
        ST_CLEAR
    } seq_state_t;

    localparam int CTL_W    = 64;
    localparam int KEEP_W   = 32;
    localparam int FULL_POS = 32;
    localparam int CONT_POS = 33;

endpackage

// File: rtl/chan_rst_ctl.sv
module chan_rst_ctl #(
    parameter int DATA_W = chan_rst_pkg::CTL_W,
    parameter int LOW_W  = chan_rst_pkg::KEEP_W,
    parameter int FULL_B = chan_rst_pkg::FULL_POS,
    parameter int CONT_B = chan_rst_pkg::CONT_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              seq_done,
    input  logic              done_full,
    output logic              start_full,
    output logic              start_cont,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HI_LSB = CONT_B + 1;

    logic [LOW_W-1:0] low_q;
    logic             full_q;
    logic             cont_q;
    logic             accept;
    logic             unused_hi;

    assign unused_hi  = ^wr_data[DATA_W-1:HI_LSB];
    assign accept     = wr_en && !busy;
    assign start_full = accept && wr_data[FULL_B];
    assign start_cont = accept && wr_data[CONT_B] && !wr_data[FULL_B];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            full_q <= 1'b0;
            cont_q <= 1'b0;
        end else if (accept) begin
            low_q  <= wr_data[LOW_W-1:0];
            full_q <= wr_data[FULL_B];
            cont_q <= wr_data[CONT_B] && !wr_data[FULL_B];
        end else if (seq_done) begin
            full_q <= 1'b0;
            cont_q <= 1'b0;
            if (done_full) begin
                low_q <= '0;
            end
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[LOW_W-1:0] = low_q;
        rd_data[FULL_B]   = full_q;
        rd_data[CONT_B]   = cont_q;
    end

    a_r7_full_wins: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !cont_q);

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> ($stable(low_q) && $stable(full_q) && $stable(cont_q)));

endmodule

// File: rtl/chan_rst_fsm.sv
module chan_rst_fsm
    import chan_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_full,
    input  logic start_cont,
    input  logic req_pending,
    input  logic prim_assigned,
    input  logic sec_reserved,
    input  logic eu_wr_ack,
    output logic eu_wr_req,
    output logic eu_wr_sel,
    output logic rel_pulse,
    output logic clr_regs,
    output logic clr_fifo,
    output logic resume,
    output logic busy,
    output logic seq_done,
    output logic done_full
);
    seq_state_t state_q, state_d;
    logic       full_q;

    // State register and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_full || start_cont) begin
                full_q <= start_full;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_full || start_cont) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = prim_assigned ? ST_RST_PRI :
                                  req_pending   ? ST_RELEASE : ST_CLEAR;
            ST_RST_PRI: if (eu_wr_ack) state_d = sec_reserved ? ST_RST_SEC : ST_RELEASE;
            ST_RST_SEC: if (eu_wr_ack) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_CLEAR;
            ST_CLEAR:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        eu_wr_req = 1'b0;
        eu_wr_sel = 1'b0;
        rel_pulse = 1'b0;
        clr_regs  = 1'b0;
        clr_fifo  = 1'b0;
        resume    = 1'b0;
        unique case (state_q)
            ST_RST_PRI: eu_wr_req = 1'b1;
            ST_RST_SEC: begin
                eu_wr_req = 1'b1;
                eu_wr_sel = 1'b1;
            end
            ST_RELEASE: rel_pulse = 1'b1;
            ST_CLEAR: begin
                clr_regs = 1'b1;
                clr_fifo = full_q;
                resume   = !full_q;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign seq_done  = (state_q == ST_CLEAR);
    assign done_full = full_q;

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eu_wr_req && !eu_wr_ack) |=> (eu_wr_req && $stable(eu_wr_sel)));

    a_r4_release_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |=> clr_regs);

    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_regs |=> (!clr_regs && !busy));

    a_r6_fifo_kept: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (clr_regs && !clr_fifo));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rel_pulse, eu_wr_req, clr_regs}));

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_full || start_cont)) |=> busy);

endmodule

// File: rtl/chan_rst_seq.sv
module chan_rst_seq #(
    parameter int DATA_W = chan_rst_pkg::CTL_W,
    parameter int LOW_W  = chan_rst_pkg::KEEP_W,
    parameter int FULL_B = chan_rst_pkg::FULL_POS,
    parameter int CONT_B = chan_rst_pkg::CONT_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              req_pending,
    input  logic              prim_assigned,
    input  logic              sec_reserved,
    input  logic              eu_wr_ack,
    output logic              eu_wr_req,
    output logic              eu_wr_sel,
    output logic              rel_pulse,
    output logic              clr_regs,
    output logic              clr_fifo,
    output logic              resume,
    output logic              busy
);
    logic start_full;
    logic start_cont;
    logic seq_done;
    logic done_full;

    chan_rst_ctl #(
        .DATA_W(DATA_W),
        .LOW_W (LOW_W),
        .FULL_B(FULL_B),
        .CONT_B(CONT_B)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .busy      (busy),
        .seq_done  (seq_done),
        .done_full (done_full),
        .start_full(start_full),
        .start_cont(start_cont),
        .rd_data   (rd_data)
    );

    chan_rst_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_full   (start_full),
        .start_cont   (start_cont),
        .req_pending  (req_pending),
        .prim_assigned(prim_assigned),
        .sec_reserved (sec_reserved),
        .eu_wr_ack    (eu_wr_ack),
        .eu_wr_req    (eu_wr_req),
        .eu_wr_sel    (eu_wr_sel),
        .rel_pulse    (rel_pulse),
        .clr_regs     (clr_regs),
        .clr_fifo     (clr_fifo),
        .resume       (resume),
        .busy         (busy),
        .seq_done     (seq_done),
        .done_full    (done_full)
    );

endmodule

// File: tb/sim_chan_rst_seq.sv
module sim_chan_rst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        req_pending = 1'b0;
    logic        prim_assigned = 1'b0;
    logic        sec_reserved = 1'b0;
    logic        eu_wr_ack = 1'b0;
    logic        eu_wr_req, eu_wr_sel, rel_pulse, clr_regs, clr_fifo, resume, busy;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    // {busy, rel_pulse, eu_wr_req, eu_wr_sel, clr_regs, clr_fifo, resume}
    localparam logic [6:0] O_IDLE = 7'b0000000;
    localparam logic [6:0] O_BUSY = 7'b1000000;
    localparam logic [6:0] O_PRI  = 7'b1010000;
    localparam logic [6:0] O_SEC  = 7'b1011000;
    localparam logic [6:0] O_REL  = 7'b1100000;
    localparam logic [6:0] O_CLRF = 7'b1000110;
    localparam logic [6:0] O_CLRC = 7'b1000101;

    wire [6:0] outs = {busy, rel_pulse, eu_wr_req, eu_wr_sel, clr_regs, clr_fifo, resume};

    chan_rst_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .req_pending(req_pending), .prim_assigned(prim_assigned), .sec_reserved(sec_reserved),
        .eu_wr_ack(eu_wr_ack), .eu_wr_req(eu_wr_req), .eu_wr_sel(eu_wr_sel),
        .rel_pulse(rel_pulse), .clr_regs(clr_regs), .clr_fifo(clr_fifo),
        .resume(resume), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [63:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 outputs", {57'd0, outs}, {57'd0, O_IDLE});
        chk("R1 rd_data", rd_data, 64'd0);
    endtask

    task automatic t_plain;
        write_word(64'hFFFF_FFFC_A5A5_0F0F);
        chk("R2 no start", {57'd0, outs}, {57'd0, O_IDLE});
        chk("R2 stored", rd_data, 64'h0000_0000_A5A5_0F0F);
    endtask

    task automatic t_full_direct;
        req_pending = 0; prim_assigned = 0; sec_reserved = 0;
        write_word(64'h1_0000_0011);
        chk("R9 busy rises", {57'd0, outs}, {57'd0, O_BUSY});
        chk("R3 bit32 live", rd_data, 64'h1_0000_0011);
        wr_en = 1'b1; wr_data = 64'h2_DEAD_BEEF;   // R8 write while busy
        step();
        wr_en = 1'b0;
        chk("R3 clear strobes", {57'd0, outs}, {57'd0, O_CLRF});
        chk("R8 ignored mid", rd_data, 64'h1_0000_0011);
        step();
        chk("R9 busy falls", {57'd0, outs}, {57'd0, O_IDLE});
        chk("R3 cleared", rd_data, 64'd0);
        step();
        chk("R8 no new sequence", {57'd0, outs}, {57'd0, O_IDLE});
    endtask

    task automatic t_cancel;
        req_pending = 1;
        write_word(64'h1_0000_0000);
        chk("R4 decide", {57'd0, outs}, {57'd0, O_BUSY});
        step();
        chk("R4 release", {57'd0, outs}, {57'd0, O_REL});
        step();
        chk("R4 clear", {57'd0, outs}, {57'd0, O_CLRF});
        step();
        chk("R9 cancel 3 cycles", {57'd0, outs}, {57'd0, O_IDLE});
        req_pending = 0;
    endtask

    task automatic t_two_units;
        prim_assigned = 1; sec_reserved = 1; eu_wr_ack = 0;
        write_word(64'h1_0000_0000);
        step();
        chk("R5 primary req", {57'd0, outs}, {57'd0, O_PRI});
        step();
        chk("R5 primary held", {57'd0, outs}, {57'd0, O_PRI});
        eu_wr_ack = 1;
        step();
        eu_wr_ack = 0;
        chk("R5 secondary req", {57'd0, outs}, {57'd0, O_SEC});
        step();
        chk("R5 secondary held", {57'd0, outs}, {57'd0, O_SEC});
        eu_wr_ack = 1;
        step();
        eu_wr_ack = 0;
        chk("R5 release after units", {57'd0, outs}, {57'd0, O_REL});
        step();
        chk("R5 clear", {57'd0, outs}, {57'd0, O_CLRF});
        step();
        chk("R5 idle", {57'd0, outs}, {57'd0, O_IDLE});
        prim_assigned = 0; sec_reserved = 0;
    endtask

    task automatic t_continue;
        prim_assigned = 1; sec_reserved = 0; eu_wr_ack = 1;
        write_word(64'h2_0000_CAFE);
        chk("R6 bit33 live", rd_data, 64'h2_0000_CAFE);
        step();
        chk("R6 primary only", {57'd0, outs}, {57'd0, O_PRI});
        step();
        chk("R6 skip secondary", {57'd0, outs}, {57'd0, O_REL});
        step();
        chk("R6 resume no fifo clear", {57'd0, outs}, {57'd0, O_CLRC});
        step();
        chk("R6 idle", {57'd0, outs}, {57'd0, O_IDLE});
        chk("R6 low kept bit33 gone", rd_data, 64'h0000_0000_0000_CAFE);
        prim_assigned = 0; eu_wr_ack = 0;
    endtask

    task automatic t_both_bits;
        write_word(64'h3_0000_0005);
        chk("R7 bit33 dropped", rd_data, 64'h1_0000_0005);
        step();
        chk("R7 full clear", {57'd0, outs}, {57'd0, O_CLRF});
        step();
        chk("R7 cleared", rd_data, 64'd0);
        chk("R10 idle quiet", {57'd0, outs}, {57'd0, O_IDLE});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain();
        t_full_direct();
        t_cancel();
        t_two_units();
        t_continue();
        t_both_bits();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule